// File: doc/BRIEF.md
# Two-Level Strided Address Sequencer

This block is a local address controller for a row-addressed memory. Software-side set-up first loads a start address, then programs up to two nested repetition levels, each with an iteration count, a stride and an idle delay. A single-cycle launch strobe then makes the block walk every point of the two-level loop nest. It places one row address per issued point on its output together with a one-cycle event pulse, and it raises a one-cycle completion flag after the last point. Level 0 is the inner loop and level 1 the outer loop. Choosing the strides can therefore produce non-sequential orders, such as 0, 2, 1, 3 from a stride of 2 inside a stride of 1.

A four-state machine controls the walk. The states are IDLE (waiting for a launch), ISSUE (an address is presented with its event pulse), GAP (idle cycles between iterations) and FIN (the completion cycle). The named transitions are:
- launch: IDLE to ISSUE, when the launch strobe is seen.
- step-inner and step-outer: ISSUE to ISSUE, when the applicable delay is zero.
- pause: ISSUE to GAP, when the applicable delay is nonzero.
- resume: GAP to ISSUE, when the delay timer reaches its last cycle.
- finish: ISSUE to FIN, after the final point.
- retire: FIN to IDLE.

Top module: `agen_top`

## Requirements
- R1: After reset the block is idle: busy_o, evt_o and done_o are 0 and addr_o is 0.
- R2: A start-address write stores the address and resets both levels to iteration 0, stride 0 and delay 0. A level write with lvl_sel 0 (inner) or 1 (outer) sets that level's iteration, stride and delay fields. Configuration writes while busy_o is 1 are ignored.
- R3: The iteration field holds the count minus one. Level 0 issues iter0+1 addresses in each outer pass, and a run issues (iter0+1)*(iter1+1) addresses; iter0=31 gives 32 addresses.
- R4: The address for counter values i0, i1 is start + i0*stride0 + i1*stride1 modulo 2^ADDR_W. Level 0 advances fastest, so start 0 with inner (iter 1, stride 2) and outer (iter 1, stride 1) yields 0, 2, 1, 3.
- R5: A launch accepted in IDLE raises evt_o with the start address in the cycle after the clock edge that samples go_i. With zero delays, addresses follow on consecutive cycles.
- R6: A nonzero delay0 inserts delay0 idle cycles (evt_o low) between consecutive inner iterations. A nonzero delay1 inserts delay1 idle cycles before the first address of each new outer pass.
- R7: done_o is high for exactly the one cycle after the last address. evt_o and done_o are never high together. busy_o is high from the first address through the done cycle and low afterwards.
- R8: A launch strobe while busy_o is 1 is ignored and does not change the running sequence.
- R9: When only level 0 is written after a start-address write, level 1 acts as a single pass (iteration 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_we | input | 1 | Start-address write strobe (also clears both levels) |
| cfg_base | input | ADDR_W | Start address |
| cfg_lvl_we | input | 1 | Level parameter write strobe |
| cfg_lvl_sel | input | 1 | Level select: 0 inner, 1 outer |
| cfg_iter | input | ITER_W | Iteration count minus one |
| cfg_stride | input | ADDR_W | Address stride of the level |
| cfg_delay | input | DLY_W | Idle cycles between iterations of the level |
| go_i | input | 1 | Launch strobe |
| addr_o | output | ADDR_W | Current row address |
| evt_o | output | 1 | One-cycle pulse per issued address |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
A corrupted loop counter shows up at the ports within one iteration. Either the address stream departs from the affine formula, or the completion pulse arrives after the wrong number of events. A wrong delay timer moves the next event pulse by at least one cycle, and a faulty state register shows up as evt_o and done_o overlapping or busy_o staying high. The bench compares every cycle of each run against a cycle-exact schedule, so each of these faults is visible within a few cycles of its cause.

// File: rtl/agen_pkg.sv
package agen_pkg;
    localparam int unsigned AGEN_LVLS = 2;
    localparam int unsigned LVL_IN    = 0;
    localparam int unsigned LVL_OUT   = 1;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_GAP   = 2'd2,
        S_FIN   = 2'd3
    } agen_state_e;
endpackage

// File: rtl/agen_cfg.sv
module agen_cfg #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned ITER_W = 6,
    parameter int unsigned DLY_W  = 3,
    parameter int unsigned LVLS   = 2,
    localparam int unsigned SEL_W = (LVLS > 1) ? $clog2(LVLS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          base_we,
    input  logic [ADDR_W-1:0]             base_in,
    input  logic                          lvl_we,
    input  logic [SEL_W-1:0]              lvl_sel,
    input  logic [ITER_W-1:0]             iter_in,
    input  logic [ADDR_W-1:0]             stride_in,
    input  logic [DLY_W-1:0]              dly_in,
    output logic [ADDR_W-1:0]             base_q,
    output logic [LVLS-1:0][ITER_W-1:0]   iter_q,
    output logic [LVLS-1:0][ADDR_W-1:0]   stride_q,
    output logic [LVLS-1:0][DLY_W-1:0]    dly_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= base_in;
    end

    for (genvar g = 0; g < LVLS; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                iter_q[g]   <= '0;
                stride_q[g] <= '0;
                dly_q[g]    <= '0;
            end else if (lvl_we && (lvl_sel == SEL_W'(g))) begin
                iter_q[g]   <= iter_in;
                stride_q[g] <= stride_in;
                dly_q[g]    <= dly_in;
            end else if (base_we) begin
                iter_q[g]   <= '0;
                stride_q[g] <= '0;
                dly_q[g]    <= '0;
            end
        end
    end
endmodule

// File: rtl/agen_lvl_cnt.sv
module agen_lvl_cnt #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + W'(1);
    end

    assign last = (cnt == lim);
endmodule

// File: rtl/agen_addr.sv
module agen_addr #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start,
    input  logic              step_in,
    input  logic              step_out,
    input  logic [ADDR_W-1:0] s_in,
    input  logic [ADDR_W-1:0] s_out,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] row_base;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_base <= '0;
            addr     <= '0;
        end else if (load) begin
            row_base <= start;
            addr     <= start;
        end else if (step_out) begin
            row_base <= row_base + s_out;
            addr     <= row_base + s_out;
        end else if (step_in) begin
            addr     <= addr + s_in;
        end
    end

    p_inner_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_in && !load && !step_out) |=> (addr == $past(addr) + $past(s_in)));
endmodule

// File: rtl/agen_gap_tmr.sv
module agen_gap_tmr #(
    parameter int unsigned DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] val,
    input  logic             run,
    output logic [DLY_W-1:0] rem
);
    always_ff @(posedge clk) begin
        if (!rst_n)                   rem <= '0;
        else if (load)                rem <= val;
        else if (run && rem != '0)    rem <= rem - DLY_W'(1);
    end
endmodule

// File: rtl/agen_top.sv
module agen_top
    import agen_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned ITER_W = 6,
    parameter int unsigned DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_base_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_lvl_we,
    input  logic              cfg_lvl_sel,
    input  logic [ITER_W-1:0] cfg_iter,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic              go_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              evt_o,
    output logic              done_o,
    output logic              busy_o
);
    localparam int unsigned LVLS = AGEN_LVLS;

    agen_state_e state, state_nx;

    logic [ADDR_W-1:0]           base_q;
    logic [LVLS-1:0][ITER_W-1:0] iter_q;
    logic [LVLS-1:0][ADDR_W-1:0] stride_q;
    logic [LVLS-1:0][DLY_W-1:0]  dly_q;
    logic [LVLS-1:0][ITER_W-1:0] cnt;
    logic [LVLS-1:0]             cnt_last;
    logic [LVLS-1:0]             cnt_clr;
    logic [LVLS-1:0]             cnt_inc;
    logic                        idle;
    logic                        ld, st_in, st_out, t_load, t_run;
    logic [DLY_W-1:0]            t_val, t_rem;

    assign idle = (state == S_IDLE);

    agen_cfg #(
        .ADDR_W(ADDR_W), .ITER_W(ITER_W), .DLY_W(DLY_W), .LVLS(LVLS)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_we  (cfg_base_we && idle),
        .base_in  (cfg_base),
        .lvl_we   (cfg_lvl_we && idle),
        .lvl_sel  (cfg_lvl_sel),
        .iter_in  (cfg_iter),
        .stride_in(cfg_stride),
        .dly_in   (cfg_delay),
        .base_q   (base_q),
        .iter_q   (iter_q),
        .stride_q (stride_q),
        .dly_q    (dly_q)
    );

    for (genvar g = 0; g < LVLS; g++) begin : g_cnt
        agen_lvl_cnt #(.W(ITER_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (cnt_clr[g]),
            .inc  (cnt_inc[g]),
            .lim  (iter_q[g]),
            .cnt  (cnt[g]),
            .last (cnt_last[g])
        );
    end

    agen_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld),
        .start   (base_q),
        .step_in (st_in),
        .step_out(st_out),
        .s_in    (stride_q[LVL_IN]),
        .s_out   (stride_q[LVL_OUT]),
        .addr    (addr_o)
    );

    agen_gap_tmr #(.DLY_W(DLY_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (t_load),
        .val  (t_val),
        .run  (t_run),
        .rem  (t_rem)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state and loop control
    always_comb begin
        state_nx = state;
        ld       = 1'b0;
        st_in    = 1'b0;
        st_out   = 1'b0;
        t_load   = 1'b0;
        t_run    = 1'b0;
        t_val    = '0;
        cnt_clr  = '0;
        cnt_inc  = '0;
        unique case (state)
            S_IDLE: begin
                if (go_i) begin
                    ld       = 1'b1;
                    cnt_clr  = '1;
                    state_nx = S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (cnt_last[LVL_IN] && cnt_last[LVL_OUT]) begin
                    state_nx = S_FIN;
                end else if (cnt_last[LVL_IN]) begin
                    cnt_clr[LVL_IN]  = 1'b1;
                    cnt_inc[LVL_OUT] = 1'b1;
                    st_out           = 1'b1;
                    if (dly_q[LVL_OUT] != '0) begin
                        t_load   = 1'b1;
                        t_val    = dly_q[LVL_OUT];
                        state_nx = S_GAP;
                    end
                end else begin
                    cnt_inc[LVL_IN] = 1'b1;
                    st_in           = 1'b1;
                    if (dly_q[LVL_IN] != '0) begin
                        t_load   = 1'b1;
                        t_val    = dly_q[LVL_IN];
                        state_nx = S_GAP;
                    end
                end
            end
            S_GAP: begin
                t_run = 1'b1;
                if (t_rem == DLY_W'(1)) state_nx = S_ISSUE;
            end
            S_FIN: begin
                state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        evt_o  = (state == S_ISSUE);
        done_o = (state == S_FIN);
        busy_o = (state != S_IDLE);
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    p_evt_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_o && done_o));
    p_go_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && go_i) |=> busy_o);
    p_gap_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP) |-> (t_rem != '0));
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt[LVL_IN] <= iter_q[LVL_IN] && cnt[LVL_OUT] <= iter_q[LVL_OUT]));
    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || ($stable(iter_q) && $stable(stride_q) && $stable(dly_q))));
endmodule

// File: tb/agen_top_tb.sv
module agen_top_tb;
    localparam int ADDR_W = 8;
    localparam int ITER_W = 6;
    localparam int DLY_W  = 3;
    localparam int MAXL   = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_base_we = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic cfg_lvl_we = 1'b0;
    logic cfg_lvl_sel = 1'b0;
    logic [ITER_W-1:0] cfg_iter = '0;
    logic [ADDR_W-1:0] cfg_stride = '0;
    logic [DLY_W-1:0] cfg_delay = '0;
    logic go_i = 1'b0;
    logic [ADDR_W-1:0] addr_o;
    logic evt_o, done_o, busy_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    bit exp_evt [MAXL];
    bit exp_done[MAXL];
    int exp_addr[MAXL];
    int exp_len;

    always #10 clk = ~clk;

    agen_top #(.ADDR_W(ADDR_W), .ITER_W(ITER_W), .DLY_W(DLY_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_base_we(cfg_base_we), .cfg_base(cfg_base),
        .cfg_lvl_we(cfg_lvl_we), .cfg_lvl_sel(cfg_lvl_sel),
        .cfg_iter(cfg_iter), .cfg_stride(cfg_stride), .cfg_delay(cfg_delay),
        .go_i(go_i), .addr_o(addr_o), .evt_o(evt_o), .done_o(done_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Cycle-exact schedule of a run; index 1 is the cycle after the launch edge.
    task automatic build_exp(input int st, input int it0, input int s0, input int d0,
                             input int it1, input int s1, input int d1);
        int t;
        for (int k = 0; k < MAXL; k++) begin
            exp_evt[k] = 0; exp_done[k] = 0; exp_addr[k] = 0;
        end
        t = 1;
        for (int i1 = 0; i1 <= it1; i1++) begin
            for (int i0 = 0; i0 <= it0; i0++) begin
                exp_evt[t]  = 1;
                exp_addr[t] = (st + i0 * s0 + i1 * s1) % (1 << ADDR_W);
                if (i0 < it0)      t += 1 + d0;
                else if (i1 < it1) t += 1 + d1;
            end
        end
        exp_done[t + 1] = 1;
        exp_len = t + 1;
    endtask

    task automatic wr_base(input int a);
        @(negedge clk);
        cfg_base_we = 1; cfg_base = ADDR_W'(a);
        @(negedge clk);
        cfg_base_we = 0;
    endtask

    task automatic wr_lvl(input int sel, input int it, input int s, input int d);
        @(negedge clk);
        cfg_lvl_we = 1; cfg_lvl_sel = sel[0];
        cfg_iter = ITER_W'(it); cfg_stride = ADDR_W'(s); cfg_delay = DLY_W'(d);
        @(negedge clk);
        cfg_lvl_we = 0;
    endtask

    // go_at: cycle at which a second launch is driven (0 = none)
    // poke: write level 0 mid-run
    task automatic run_seq(input string req, input int go_at, input bit poke);
        @(negedge clk);
        go_i = 1;
        @(negedge clk);
        go_i = 0;
        for (int c = 1; c <= exp_len; c++) begin
            if (c > 1) @(negedge clk);
            go_i = 0;
            cfg_lvl_we = 0;
            chk(evt_o == exp_evt[c], req, $sformatf("evt_o cycle %0d", c), int'(evt_o), int'(exp_evt[c]));
            chk(done_o == exp_done[c], "R7", $sformatf("done_o cycle %0d", c), int'(done_o), int'(exp_done[c]));
            if (exp_evt[c])
                chk(int'(addr_o) == exp_addr[c], req, $sformatf("addr_o cycle %0d", c), int'(addr_o), exp_addr[c]);
            chk(busy_o == 1'b1, "R7", $sformatf("busy_o cycle %0d", c), int'(busy_o), 1);
            if (go_at != 0 && c == go_at) go_i = 1;
            if (poke && c == 2) begin
                cfg_lvl_we = 1; cfg_lvl_sel = 0;
                cfg_iter = ITER_W'(9); cfg_stride = ADDR_W'(7); cfg_delay = DLY_W'(2);
            end
        end
        @(negedge clk);
        go_i = 0;
        cfg_lvl_we = 0;
        chk(busy_o == 1'b0 && done_o == 1'b0, "R7", "idle after done", int'(busy_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        int st, a0, b0, c0, a1, b1, c1;
        seed = 13579;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(busy_o == 0, "R1", "busy_o", int'(busy_o), 0);
        chk(evt_o == 0, "R1", "evt_o", int'(evt_o), 0);
        chk(done_o == 0, "R1", "done_o", int'(done_o), 0);
        chk(addr_o == 0, "R1", "addr_o", int'(addr_o), 0);
        rst_n = 1;

        // R3 R5: single level 0,1,2,3
        wr_base(0); wr_lvl(0, 3, 1, 0);
        build_exp(0, 3, 1, 0, 0, 0, 0);
        run_seq("R5", 0, 0);

        // R4: nested order 0,2,1,3
        wr_base(0); wr_lvl(0, 1, 2, 0); wr_lvl(1, 1, 1, 0);
        build_exp(0, 1, 2, 0, 1, 1, 0);
        run_seq("R4", 0, 0);

        // R6: inner delay 1 interleaves
        wr_base(0); wr_lvl(0, 1, 1, 1);
        build_exp(0, 1, 1, 1, 0, 0, 0);
        run_seq("R6", 0, 0);

        // R6: outer delay
        wr_base(5); wr_lvl(0, 2, 3, 0); wr_lvl(1, 2, 16, 2);
        build_exp(5, 2, 3, 0, 2, 16, 2);
        run_seq("R6", 0, 0);

        // R3: 32-address pass
        wr_base(0); wr_lvl(0, 31, 1, 0);
        build_exp(0, 31, 1, 0, 0, 0, 0);
        run_seq("R3", 0, 0);

        // R2 R9: start write clears a stale outer level
        wr_lvl(1, 2, 8, 3);
        wr_base(40); wr_lvl(0, 3, 2, 0);
        build_exp(40, 3, 2, 0, 0, 0, 0);
        run_seq("R9", 0, 0);

        // R8: launch during busy ignored
        wr_base(0); wr_lvl(0, 2, 1, 1); wr_lvl(1, 1, 10, 0);
        build_exp(0, 2, 1, 1, 1, 10, 0);
        run_seq("R8", 3, 0);

        // R2: config write while busy ignored, both in this run and the next
        run_seq("R2", 0, 1);
        run_seq("R2", 0, 0);

        // R4: address wrap modulo 2^ADDR_W
        wr_base(250); wr_lvl(0, 3, 3, 0); wr_lvl(1, 1, 200, 1);
        build_exp(250, 3, 3, 0, 1, 200, 1);
        run_seq("R4", 0, 0);

        // Random runs
        for (int r = 0; r < 25; r++) begin
            st = int'($urandom_range(0, 255));
            a0 = int'($urandom_range(0, 5)); b0 = int'($urandom_range(0, 255)); c0 = int'($urandom_range(0, 3));
            a1 = int'($urandom_range(0, 5)); b1 = int'($urandom_range(0, 255)); c1 = int'($urandom_range(0, 3));
            wr_base(st); wr_lvl(0, a0, b0, c0); wr_lvl(1, a1, b1, c1);
            build_exp(st, a0, b0, c0, a1, b1, c1);
            run_seq("R4", 0, 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule